// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides each cycle whether the hart must take an interrupt, and which cause code it should report. The candidates are the interrupt lines that are both pending and enabled. A delegation mask splits them into two groups. The machine group consists of the non-delegated bits. It is live when the hart runs below machine privilege, or in machine privilege with the machine global enable set. The supervisor group consists of the delegated bits. It is live below supervisor privilege, or in supervisor privilege with the supervisor global enable set. Among the live candidates, the lowest-numbered bit wins. The cause output reports its index with the top bit set, which marks the cause as an interrupt.

A small register file holds three registers: the software-visible pending bits, the enable bits and the delegation mask. Software writes pass through fixed legality masks. Two supervisor aliases are also provided, one for pending and one for enable. Each alias reads the machine value ANDed with the delegation mask and writes only the delegated bits. Level interrupt lines from outside arrive on `extPend`. They are ORed into the pending view without being stored.

The bit positions are fixed as follows: supervisor software at 1, machine software at 3, supervisor timer at 5, machine timer at 7, supervisor external at 9 and coprocessor at 12. Privilege levels are encoded as user 0, supervisor 1, hypervisor 2 and machine 3.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset, the stored pending, enable and delegation registers are all zero. With `extPend` at zero, every `rdData` view reads 0, `takeIrq` is 0 and `causeOut` is 0.
- R2: A non-delegated candidate is live when `priv` < 3, or when `priv` = 3 and `mIe` = 1. With `priv` = 3 and `mIe` = 0, no interrupt is taken.
- R3: A delegated candidate is live only when `priv` = 0, or when `priv` = 1 and `sIe` = 1. At `priv` = 2 or 3, delegated candidates are never taken.
- R4: The candidates are (stored pending OR `extPend`) AND enable. When any live candidate exists, `takeIrq` = 1 and `causeOut` = 0x80000000 plus the index of the lowest live candidate bit.
- R5: When no candidate is live, `takeIrq` = 0 and `causeOut` = 0.
- R6: A write with `wrSel` = 2 updates only the delegation bits 1, 5, 9 and 12 (mask 0x1222). All other delegation bits stay 0.
- R7: A write with `wrSel` = 1 updates only the enable bits in mask 0x12AA, which covers bits 1, 3, 5, 7, 9 and 12.
- R8: A write with `wrSel` = 0 updates only the stored pending bits 1 and 5 (mask 0x22). A read with `rdSel` = 0 returns the stored pending bits OR `extPend`.
- R9: A read with `rdSel` = 3 returns the pending view ANDed with the delegation mask. A read with `rdSel` = 4 returns enable ANDed with the delegation mask. A read with `rdSel` = 1 returns enable, and `rdSel` = 2 returns the delegation mask.
- R10: A write with `wrSel` = 4 changes only the enable bits that are currently delegated. A write with `wrSel` = 3 changes only stored pending bit 1, and only while bit 1 is delegated.
- R11: Writes with `wrSel` codes 5 to 7 change no register. Reads with `rdSel` codes 5 to 7 return 0.
- R12: A write takes effect at the rising clock edge where `wrEn` is high. `rdData`, `takeIrq` and `causeOut` follow their inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Write target: 0 pending, 1 enable, 2 delegation, 3 supervisor pending, 4 supervisor enable |
| wrData | input | 32 | Write data |
| rdSel | input | 3 | Read view, using the same encoding as `wrSel` |
| rdData | output | 32 | Selected register view |
| extPend | input | 32 | Level interrupt lines from outside, ORed into pending |
| priv | input | 2 | Current privilege level (0 U, 1 S, 2 H, 3 M) |
| mIe | input | 1 | Machine global interrupt enable |
| sIe | input | 1 | Supervisor global interrupt enable |
| takeIrq | output | 1 | An interrupt must be taken |
| causeOut | output | 32 | Cause code: top bit set plus the winning index, or 0 |

## Verification
On every cycle, the assertions check the legality masks on the stored registers and that a reported cause names a pending, enabled bit. They also check that the output is all-zero when nothing is taken, that no interrupt is taken in machine mode while the machine enable is clear, that no delegated cause is taken at hypervisor level, and that supervisor enable writes leave non-delegated bits alone. Whether the winner is truly the lowest live bit is shown only by the bench. So are the exact read-back value after each write sequence and the combined privilege and enable cases. The bench compares these against its own model across directed and random scenarios.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int XLEN_DEF = 32;
  localparam int SEL_W    = 3;
  localparam int BIT_SSIP = 1;
  localparam int BIT_MSIP = 3;
  localparam int BIT_STIP = 5;
  localparam int BIT_MTIP = 7;
  localparam int BIT_SEIP = 9;
  localparam int BIT_COP  = 12;

  typedef enum logic [SEL_W-1:0] {
    SEL_MPEND = 3'd0,
    SEL_MEN   = 3'd1,
    SEL_DELEG = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_SEN   = 3'd4
  } regSelE;

  typedef struct packed {
    logic wrMPend;
    logic wrMEn;
    logic wrDeleg;
    logic wrSPend;
    logic wrSEn;
  } wrStrobeT;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output wrStrobeT         strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (wrSel)
        SEL_MPEND: strobe.wrMPend = 1'b1;
        SEL_MEN:   strobe.wrMEn   = 1'b1;
        SEL_DELEG: strobe.wrDeleg = 1'b1;
        SEL_SPEND: strobe.wrSPend = 1'b1;
        SEL_SEN:   strobe.wrSEn   = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int XLEN = XLEN_DEF
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobeT        strobe,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] extPend,
  input  logic [1:0]      priv,
  input  logic            mIe,
  input  logic            sIe,
  output logic [XLEN-1:0] pendEff,
  output logic [XLEN-1:0] enQ,
  output logic [XLEN-1:0] delegQ,
  output logic            takeIrq,
  output logic [XLEN-1:0] causeOut
);
  localparam int IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] DELEG_MASK =
    (ONE << BIT_SSIP) | (ONE << BIT_STIP) | (ONE << BIT_SEIP) | (ONE << BIT_COP);
  localparam logic [XLEN-1:0] EN_MASK =
    DELEG_MASK | (ONE << BIT_MSIP) | (ONE << BIT_MTIP);
  localparam logic [XLEN-1:0] PEND_MASK = (ONE << BIT_SSIP) | (ONE << BIT_STIP);
  localparam logic [XLEN-1:0] SPEND_MASK = ONE << BIT_SSIP;

  logic [XLEN-1:0] pendSwQ;
  logic [XLEN-1:0] sPendMask;

  assign sPendMask = SPEND_MASK & delegQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSwQ <= '0;
      enQ     <= '0;
      delegQ  <= '0;
    end else begin
      if (strobe.wrMPend)
        pendSwQ <= (pendSwQ & ~PEND_MASK) | (wrData & PEND_MASK);
      else if (strobe.wrSPend)
        pendSwQ <= (pendSwQ & ~sPendMask) | (wrData & sPendMask);
      if (strobe.wrMEn)
        enQ <= (enQ & ~EN_MASK) | (wrData & EN_MASK);
      else if (strobe.wrSEn)
        enQ <= (enQ & ~delegQ) | (wrData & delegQ);
      if (strobe.wrDeleg)
        delegQ <= (delegQ & ~DELEG_MASK) | (wrData & DELEG_MASK);
    end
  end

  assign pendEff = pendSwQ | extPend;

  logic            mLive;
  logic            sLive;
  logic [XLEN-1:0] cand;
  logic [XLEN-1:0] liveVec;

  assign mLive   = (priv < 2'd3) || (priv == 2'd3 && mIe);
  assign sLive   = (priv < 2'd1) || (priv == 2'd1 && sIe);
  assign cand    = pendEff & enQ;
  assign liveVec = (cand & ~delegQ & {XLEN{mLive}}) | (cand & delegQ & {XLEN{sLive}});

  logic [IDXW-1:0] winIdx;

  always_comb begin
    winIdx = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (liveVec[i]) winIdx = IDXW'(i);
    end
  end

  always_comb begin
    takeIrq  = |liveVec;
    causeOut = '0;
    if (takeIrq) begin
      causeOut[XLEN-1]   = 1'b1;
      causeOut[IDXW-1:0] = winIdx;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter int XLEN = XLEN_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [XLEN-1:0]  wrData,
  input  logic [SEL_W-1:0] rdSel,
  output logic [XLEN-1:0]  rdData,
  input  logic [XLEN-1:0]  extPend,
  input  logic [1:0]       priv,
  input  logic             mIe,
  input  logic             sIe,
  output logic             takeIrq,
  output logic [XLEN-1:0]  causeOut
);
  wrStrobeT        strobe;
  logic [XLEN-1:0] pendEff;
  logic [XLEN-1:0] enQ;
  logic [XLEN-1:0] delegQ;

  irq_prio_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  irq_prio_dp #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .extPend  (extPend),
    .priv     (priv),
    .mIe      (mIe),
    .sIe      (sIe),
    .pendEff  (pendEff),
    .enQ      (enQ),
    .delegQ   (delegQ),
    .takeIrq  (takeIrq),
    .causeOut (causeOut)
  );

  always_comb begin
    unique case (rdSel)
      SEL_MPEND: rdData = pendEff;
      SEL_MEN:   rdData = enQ;
      SEL_DELEG: rdData = delegQ;
      SEL_SPEND: rdData = pendEff & delegQ;
      SEL_SEN:   rdData = enQ & delegQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int XLEN = XLEN_DEF
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [SEL_W-1:0] wrSel,
  input logic [XLEN-1:0]  extPend,
  input logic [1:0]       priv,
  input logic             mIe,
  input logic             takeIrq,
  input logic [XLEN-1:0]  causeOut,
  input logic [XLEN-1:0]  pendEff,
  input logic [XLEN-1:0]  enQ,
  input logic [XLEN-1:0]  delegQ
);
  localparam int IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] DMASK = XLEN'(32'h1222);
  localparam logic [XLEN-1:0] EMASK = XLEN'(32'h12AA);
  localparam logic [XLEN-1:0] PMASK = XLEN'(32'h0022);

  logic [XLEN-1:0] candChk;
  assign candChk = pendEff & enQ;

  a_r6_deleg_legal: assert property (@(posedge clk) disable iff (!rstN)
    (delegQ & ~DMASK) == '0);

  a_r7_enable_legal: assert property (@(posedge clk) disable iff (!rstN)
    (enQ & ~EMASK) == '0);

  a_r8_pend_legal: assert property (@(posedge clk) disable iff (!rstN)
    (pendEff & ~extPend & ~PMASK) == '0);

  a_r4_cause_is_cand: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (causeOut[XLEN-1] && candChk[causeOut[IDXW-1:0]]));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> causeOut == '0);

  a_r2_m_masked: assert property (@(posedge clk) disable iff (!rstN)
    (priv == 2'd3 && !mIe) |-> !takeIrq);

  a_r3_h_no_deleg: assert property (@(posedge clk) disable iff (!rstN)
    (priv == 2'd2 && takeIrq) |-> !delegQ[causeOut[IDXW-1:0]]);

  a_r10_sen_scope: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd4) |=> ((enQ ^ $past(enQ)) & ~delegQ) == '0);
endmodule

bind irq_prio_sel irq_prio_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_irq_prio_sel.sv
module test_irq_prio_sel;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrSel = '0;
  logic [XL-1:0] wrData = '0;
  logic [2:0]    rdSel = '0;
  logic [XL-1:0] rdData;
  logic [XL-1:0] extPend = '0;
  logic [1:0]    priv = 2'd3;
  logic          mIe = 1'b0;
  logic          sIe = 1'b0;
  logic          takeIrq;
  logic [XL-1:0] causeOut;

  int checks = 0;
  int errors = 0;
  logic [XL-1:0] mp = '0, me = '0, md = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_sel i_irq_prio_sel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .extPend(extPend), .priv(priv),
    .mIe(mIe), .sIe(sIe), .takeIrq(takeIrq), .causeOut(causeOut)
  );

  function automatic logic [XL-1:0] modelRead(input logic [2:0] s);
    logic [XL-1:0] p;
    p = mp | extPend;
    case (s)
      3'd0: return p;
      3'd1: return me;
      3'd2: return md;
      3'd3: return p & md;
      3'd4: return me & md;
      default: return '0;
    endcase
  endfunction

  function automatic logic [XL:0] modelSel();
    logic [XL-1:0] c;
    logic mL, sL;
    c  = (mp | extPend) & me;
    mL = (priv != 2'd3) || mIe;
    sL = (priv == 2'd0) || (priv == 2'd1 && sIe);
    for (int i = 0; i < XL; i++) begin
      if (c[i] && ((!md[i] && mL) || (md[i] && sL)))
        return {1'b1, 1'b1, 26'd0, 5'(i)};
    end
    return '0;
  endfunction

  task automatic doWrite(input logic [2:0] s, input logic [XL-1:0] d);
    logic [XL-1:0] m;
    @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(posedge clk);
    case (s)
      3'd0: mp = (mp & ~32'h22) | (d & 32'h22);
      3'd1: me = (me & ~32'h12AA) | (d & 32'h12AA);
      3'd2: md = (md & ~32'h1222) | (d & 32'h1222);
      3'd3: begin m = 32'h2 & md; mp = (mp & ~m) | (d & m); end
      3'd4: me = (me & ~md) | (d & md);
      default: ;
    endcase
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCtx(input logic [1:0] p, input logic m, input logic s,
                        input logic [XL-1:0] e);
    @(negedge clk);
    priv = p; mIe = m; sIe = s; extPend = e;
  endtask

  task automatic chkOut(input string req);
    logic [XL:0] ex;
    #1;
    ex = modelSel();
    checks++;
    if (takeIrq !== ex[XL] || causeOut !== ex[XL-1:0]) begin
      errors++;
      $display("FAIL %s take/cause act=%b/%h exp=%b/%h", req, takeIrq, causeOut,
               ex[XL], ex[XL-1:0]);
    end
  endtask

  task automatic chkReads(input string req);
    for (int s = 0; s < 8; s++) begin
      rdSel = 3'(s);
      #1;
      checks++;
      if (rdData !== modelRead(3'(s))) begin
        errors++;
        $display("FAIL %s rdSel=%0d act=%h exp=%h", req, s, rdData, modelRead(3'(s)));
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    chkOut("R1");
    chkReads("R1");

    // R6 R7 R8: masks on full writes
    doWrite(3'd2, 32'hFFFF_FFFF); chkReads("R6");
    doWrite(3'd1, 32'hFFFF_FFFF); chkReads("R7");
    doWrite(3'd0, 32'hFFFF_FFFF); chkReads("R8");
    // R11: unused codes leave state intact
    doWrite(3'd5, 32'h0); doWrite(3'd7, 32'h0); chkReads("R11");
    // R12: write lands on the edge
    doWrite(3'd2, 32'h0); chkReads("R12");

    // R4: all pending, machine mode enabled, nothing delegated
    setCtx(2'd3, 1'b1, 1'b0, 32'h12AA); chkOut("R4");
    // R2: machine mode with global enable clear
    setCtx(2'd3, 1'b0, 1'b1, 32'h12AA); chkOut("R2");
    // R3: delegated ones out of reach in machine mode
    doWrite(3'd2, 32'h1222);
    setCtx(2'd3, 1'b1, 1'b1, 32'h12AA); chkOut("R3");
    // R3: hypervisor level with only delegated pending
    doWrite(3'd0, 32'h0);
    setCtx(2'd2, 1'b1, 1'b1, 32'h1222); chkOut("R3");
    // R3: supervisor with sIe clear vs set
    setCtx(2'd1, 1'b0, 1'b0, 32'h1222); chkOut("R3");
    setCtx(2'd1, 1'b0, 1'b1, 32'h1020); chkOut("R3");
    // R2: user mode always reaches non-delegated
    setCtx(2'd0, 1'b0, 1'b0, 32'h0080); chkOut("R2");
    // R5: nothing pending
    setCtx(2'd0, 1'b1, 1'b1, 32'h0); chkOut("R5");
    // R10: supervisor writes
    doWrite(3'd2, 32'h0020);
    doWrite(3'd4, 32'h0);        chkReads("R10");
    doWrite(3'd3, 32'hFFFF_FFFF); chkReads("R10");
    doWrite(3'd2, 32'h0002);
    doWrite(3'd3, 32'hFFFF_FFFF); chkReads("R10");
    doWrite(3'd3, 32'h0);         chkReads("R9");

    for (int n = 0; n < 1500; n++) begin
      logic [XL-1:0] d, e;
      d = $urandom();
      e = ($urandom() % 4 == 0) ? $urandom() : ($urandom() & 32'h12AA);
      doWrite(3'($urandom() % 8), d);
      setCtx(2'($urandom()), 1'($urandom()), 1'($urandom()), e);
      chkOut("R4");
      chkReads("R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule